// File: doc/BRIEF.md
# Interrupt Status and Masking Controller

This block gathers single-cycle event strobes from a bus-protocol engine and from a DMA/script sequencer. It records each event in a sticky status register. Software can read these registers and clear them.

The block classifies every event as fatal or nonfatal. The classification depends on whether the controller runs as initiator or as target. A fatal event asks the sequencer to halt. A nonfatal event lets the script keep running. Per-bit enable registers decide which recorded events raise the pending flag and the active-low interrupt request. A masked event is still recorded, so software can poll for it.

The register port has one address bus and separate read and write strobes. There are three status registers: two for bus events and one for DMA events. Reading a status register clears it. There are three matching enable registers, which can be read and written. A mode input selects initiator or target operation. A control input stops an enabled attention event from halting the sequencer while in target mode.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, all status and enable bits read 0, `pend_o` is 0, `irq_no` is 1 and `halt_o` is 0.
- R2: An event strobe sets its status bit at the next clock edge, whether the bit is enabled or not. The bit stays set until its register is read.
- R3: A read (`rd_i`) at address 0 (bus A), 1 (bus B) or 2 (DMA) returns that status register combinationally and clears it at the clock edge. A bit whose event arrives in the same cycle as the read stays set.
- R4: A write (`wr_i`) at address 4, 5 or 6 loads the enable register for bus A, bus B or DMA. A read at that address returns the value written.
- R5: `pend_o` is 1 and `irq_no` is 0 exactly while some status bit is set together with its enable bit. Both return to inactive once no such bit remains.
- R6: A masked nonfatal event sets its status bit, and raises neither `pend_o`, `irq_no` nor `halt_o`.
- R7: An enabled fatal event raises `pend_o` and drives `halt_o` high for exactly one cycle, in the cycle after the strobe.
- R8: A masked fatal event pulses `halt_o` but leaves `pend_o` at 0 and `irq_no` at 1.
- R9: In initiator mode, the nonfatal events are bus A bit 1 (function complete), bit 2 (selected) and bit 3 (reselected), and bus B bit 0 (handshake timer) and bit 1 (general timer). Every other bus bit is fatal, including bus A bit 4 (attention).
- R10: In target mode, bus A bit 4 (attention) is also nonfatal when it is masked, or when `phd_i` is 1.
- R11: In target mode with `phd_i` at 0, an enabled attention event halts the sequencer.
- R12: DMA bit 0 (interrupt on the fly) is nonfatal in both modes. All other DMA bits are fatal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tgt_mode_i | input | 1 | 1 = target mode, 0 = initiator mode |
| phd_i | input | 1 | In target mode, stops an enabled attention event from halting the sequencer |
| ev_a_i | input | 8 | Bus-side event strobes, group A |
| ev_b_i | input | 8 | Bus-side event strobes, group B |
| ev_d_i | input | 8 | DMA-side event strobes |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe; clears the status register it reads |
| wr_i | input | 1 | Write strobe, for enable registers only |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| pend_o | output | 1 | Pending summary flag |
| irq_no | output | 1 | Interrupt request, active low |
| halt_o | output | 1 | One-cycle halt request to the sequencer |

## Verification
All results come from registers that change on the edge at which an event strobe or a register write is sampled. Status bits, `pend_o`, `irq_no` and `halt_o` therefore become valid one cycle after the stimulus. Read data is combinational and is valid in the same cycle as the address. The bench drives inputs on the falling edge. It checks read data just after driving, within that same cycle. It checks every registered output at the next falling edge, half a period after the edge that updates it. It checks one falling edge later to confirm that `halt_o` has already dropped.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_GRP  = 3;

  // group order: 0 = bus A, 1 = bus B, 2 = DMA
  localparam logic [ADDR_W-1:0] STAT_BASE = 3'd0;
  localparam logic [ADDR_W-1:0] EN_BASE   = 3'd4;

  // bit positions used for classification
  localparam int unsigned A_CMP = 1;
  localparam int unsigned A_SEL = 2;
  localparam int unsigned A_RSL = 3;
  localparam int unsigned A_ATN = 4;
  localparam int unsigned B_HTH = 0;
  localparam int unsigned B_GEN = 1;
  localparam int unsigned D_OTF = 0;
endpackage

// File: rtl/irq_class.sv
module irq_class
  import irq_mask_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         tgt_mode_i,
  input  logic         phd_i,
  input  logic         atn_en_i,
  output logic [W-1:0] fatal_a_o,
  output logic [W-1:0] fatal_b_o,
  output logic [W-1:0] fatal_d_o
);
  logic atn_nonfatal;

  // target mode: attention halts only when enabled and not suppressed
  assign atn_nonfatal = tgt_mode_i && !(atn_en_i && !phd_i);

  always_comb begin
    fatal_a_o = '1;
    fatal_b_o = '1;
    fatal_d_o = '1;
    fatal_a_o[A_CMP] = 1'b0;
    fatal_a_o[A_SEL] = 1'b0;
    fatal_a_o[A_RSL] = 1'b0;
    fatal_a_o[A_ATN] = !atn_nonfatal;
    fatal_b_o[B_HTH] = 1'b0;
    fatal_b_o[B_GEN] = 1'b0;
    fatal_d_o[D_OTF] = 1'b0;
  end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_mask_pkg::*;
#(
  parameter int unsigned          W        = REG_W,
  parameter logic [ADDR_W-1:0]    STAT_ADR = STAT_BASE,
  parameter logic [ADDR_W-1:0]    EN_ADR   = EN_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      ev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      stat_o,
  output logic [W-1:0]      en_o
);
  logic rd_hit, wr_hit;

  assign rd_hit = rd_i && (addr_i == STAT_ADR);
  assign wr_hit = wr_i && (addr_i == EN_ADR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      en_o   <= '0;
    end else begin
      stat_o <= (rd_hit ? '0 : stat_o) | ev_i;
      if (wr_hit) en_o <= wdata_i;
    end
  end

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_hit) |-> ((stat_o & $past(stat_o)) == $past(stat_o)));

  a_r3_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_hit) |-> (stat_o == $past(ev_i)));

  a_r4_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_hit) |-> (en_o == $past(wdata_i)));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgt_mode_i,
  input  logic              phd_i,
  input  logic [REG_W-1:0]  ev_a_i,
  input  logic [REG_W-1:0]  ev_b_i,
  input  logic [REG_W-1:0]  ev_d_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              pend_o,
  output logic              irq_no,
  output logic              halt_o
);
  logic [REG_W-1:0] ev   [N_GRP];
  logic [REG_W-1:0] stat [N_GRP];
  logic [REG_W-1:0] en   [N_GRP];
  logic [REG_W-1:0] fatal[N_GRP];
  logic [N_GRP-1:0] grp_pend, grp_halt;
  logic             halt_q;

  assign ev[0] = ev_a_i;
  assign ev[1] = ev_b_i;
  assign ev[2] = ev_d_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_bank
    irq_stat_bank #(
      .W       (REG_W),
      .STAT_ADR(STAT_BASE + ADDR_W'(g)),
      .EN_ADR  (EN_BASE + ADDR_W'(g))
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev[g]),
      .addr_i (addr_i),
      .rd_i   (rd_i),
      .wr_i   (wr_i),
      .wdata_i(wdata_i),
      .stat_o (stat[g]),
      .en_o   (en[g])
    );
    assign grp_pend[g] = |(stat[g] & en[g]);
    assign grp_halt[g] = |(ev[g] & fatal[g]);
  end

  irq_class #(.W(REG_W)) u_class (
    .tgt_mode_i(tgt_mode_i),
    .phd_i     (phd_i),
    .atn_en_i  (en[0][A_ATN]),
    .fatal_a_o (fatal[0]),
    .fatal_b_o (fatal[1]),
    .fatal_d_o (fatal[2])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else         halt_q <= |grp_halt;
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (addr_i == STAT_BASE + ADDR_W'(g)) rdata_o = stat[g];
      if (addr_i == EN_BASE + ADDR_W'(g))   rdata_o = en[g];
    end
  end

  assign pend_o = |grp_pend;
  assign irq_no = !pend_o;
  assign halt_o = halt_q;

  a_r7_halt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(|{ev_a_i, ev_b_i, ev_d_i}));

  a_r12_otf_no_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ev_d_i) == REG_W'(1) && $past(ev_a_i) == '0 && $past(ev_b_i) == '0)
      |-> !halt_o);

  a_r5_pin_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no != pend_o);
endmodule

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_mask_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tgt = 1'b0, phd = 1'b0;
  logic [7:0] ev_a = '0, ev_b = '0, ev_d = '0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pend, irq_n, halt;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tgt_mode_i(tgt), .phd_i(phd),
    .ev_a_i(ev_a), .ev_b_i(ev_b), .ev_d_i(ev_d), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .pend_o(pend), .irq_no(irq_n), .halt_o(halt)
  );

  typedef struct packed {
    logic       tgt, phd;
    logic [7:0] en_a, en_b, en_d, ev_a, ev_b, ev_d;
    logic       halt, pend;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0}, // R6
    '{1'b0, 1'b0, 8'h02, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 1'b0, 1'b1}, // R5
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0}, // R8
    '{1'b0, 1'b0, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b1, 1'b1}, // R7
    '{1'b0, 1'b0, 8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b1, 1'b1}, // R9 atn fatal
    '{1'b1, 1'b0, 8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b1, 1'b1}, // R11
    '{1'b1, 1'b1, 8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 1'b1}, // R10 phd
    '{1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0}, // R10 masked
    '{1'b0, 1'b0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h03, 8'h00, 1'b0, 1'b1}, // R9 timers
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h00, 1'b1, 1'b0}, // R9 B fatal
    '{1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 1'b0, 1'b1}, // R12
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0}, // R12
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 8'h02, 1'b1, 1'b1}, // R12 dma fatal
    '{1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h0E, 8'h00, 8'h00, 1'b0, 1'b0}  // R6 target
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a; rd = 1'b1;
    #1 chk(req, rdata, exp);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic outs_chk(input string req, input logic h, input logic p);
    chk({req, " halt"}, {7'd0, halt}, {7'd0, h});
    chk({req, " pend"}, {7'd0, pend}, {7'd0, p});
    chk({req, " irq_n"}, {7'd0, irq_n}, {7'd0, !p});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    outs_chk("R1", 1'b0, 1'b0);
    for (int a = 0; a < 7; a++) if (a != 3) rd_chk("R1", 3'(a), 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      tgt = VEC[i].tgt; phd = VEC[i].phd;
      reg_wr(3'd4, VEC[i].en_a);
      reg_wr(3'd5, VEC[i].en_b);
      reg_wr(3'd6, VEC[i].en_d);
      ev_a = VEC[i].ev_a; ev_b = VEC[i].ev_b; ev_d = VEC[i].ev_d;
      @(negedge clk);
      ev_a = '0; ev_b = '0; ev_d = '0;
      outs_chk($sformatf("vec%0d R6/R7/R8", i), VEC[i].halt, VEC[i].pend);
      @(negedge clk);
      chk($sformatf("vec%0d R7 pulse", i), {7'd0, halt}, 8'h00);
      rd_chk("R2", 3'd0, VEC[i].ev_a);
      rd_chk("R2", 3'd1, VEC[i].ev_b);
      rd_chk("R2", 3'd2, VEC[i].ev_d);
      outs_chk("R5 cleared", 1'b0, 1'b0);
    end

    // R4 enable readback
    tgt = 1'b0; phd = 1'b0;
    reg_wr(3'd4, 8'hA5); reg_wr(3'd5, 8'h3C); reg_wr(3'd6, 8'h81);
    rd_chk("R4", 3'd4, 8'hA5);
    rd_chk("R4", 3'd5, 8'h3C);
    rd_chk("R4", 3'd6, 8'h81);

    // R2 stickiness over idle cycles, R3 read with concurrent event
    reg_wr(3'd4, 8'h00);
    ev_a = 8'h04;
    @(negedge clk);
    ev_a = '0;
    repeat (5) @(negedge clk);
    rd_chk("R2 hold", 3'd0, 8'h04);
    ev_a = 8'h08;
    addr = 3'd0; rd = 1'b1;
    #1 chk("R3 read value", rdata, 8'h00);
    @(negedge clk);
    rd = 1'b0; ev_a = '0;
    rd_chk("R3 same-cycle event kept", 3'd0, 8'h08);
    rd_chk("R3 cleared", 3'd0, 8'h00);

    // R5 pend follows enable of an already-set bit
    ev_b = 8'h02;
    @(negedge clk);
    ev_b = '0;
    outs_chk("R5 masked", 1'b0, 1'b0);
    reg_wr(3'd5, 8'h02);
    outs_chk("R5 late enable", 1'b0, 1'b1);
    reg_wr(3'd5, 8'h00);
    outs_chk("R5 late mask", 1'b0, 1'b0);
    rd_chk("R5", 3'd1, 8'h02);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule